// File: doc/BRIEF.md
# Auto-Reload Decrementer

This block is a down-counter that advances on a time-base tick enable. Software loads it through a write port. On each enabled tick it counts down by one. When a counted step takes it from one to zero, it raises a single-cycle event pulse. That pulse is meant to set the decrementer status flag in a separate status register.

A second register holds an auto-reload value. When the reload-enable input is high at the terminal tick and that register is non-zero, the counter takes the reload value in place of zero and keeps running. A reload value of zero never reloads, so the counter cannot retrigger itself forever. Without a reload, the counter parks at zero and stays silent until software writes it again.

Control is a three-state machine:
- STOPPED: the count is zero.
- COUNTING: the count is above one.
- FINAL: the count is exactly one.

The transitions are:
- A software write moves to STOPPED, FINAL or COUNTING, according to the written value.
- A tick in COUNTING with a count of two moves to FINAL.
- A tick in FINAL fires the event. It then moves to STOPPED if there is no reload, to FINAL if the reload value is one, and to COUNTING otherwise.

Top module: `tdec_top`

## Requirements
- R1: Reset (active-low `rst_n`) clears the counter and the reload register to zero, and holds `zero_evt` low.
- R2: A counter write loads `cnt_wr_data` at the next edge and never produces an event, even when the value written is zero.
- R3: With `tick_en` high and a count above one, the count drops by exactly one per edge. With `tick_en` low, the count holds.
- R4: A tick at a count of one raises `zero_evt` for exactly one cycle. The pulse is visible in the cycle after that edge, together with the new count.
- R5: With reload disabled, the terminal tick leaves the count at zero. Further ticks leave it at zero and produce no events.
- R6: With `rld_enable` high and a non-zero reload register, the terminal tick loads the reload value instead of zero and still produces the event.
- R7: With `rld_enable` high and a reload register of zero, the terminal tick leaves the count at zero and it stays there.
- R8: A counter write in the same cycle as a tick, including a terminal tick, wins. The written value is loaded and no event is produced.
- R9: A reload register write takes effect at the next edge. A terminal tick in the same cycle uses the previous reload value.
- R10: With a reload value of one and reload enabled, every tick at count one produces an event and the count stays at one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Time-base tick; one count step per cycle it is high |
| cnt_wr_en | input | 1 | Software write strobe for the counter |
| cnt_wr_data | input | 32 | Value loaded into the counter |
| rld_wr_en | input | 1 | Software write strobe for the reload register |
| rld_wr_data | input | 32 | Value loaded into the reload register |
| rld_enable | input | 1 | Auto-reload enable from the control word |
| count_val | output | 32 | Current counter value |
| zero_evt | output | 1 | One-cycle pulse that sets the decrementer status flag |

## Verification
The bench targets these corner cases, each with the fault it would expose:
- A zero written straight to the counter. A design that triggers on the count equalling zero would pulse here.
- Ticks that keep arriving after the count parks at zero. A wrapping design would roll over to all ones.
- A zero reload value with reload enabled. A careless design would retrigger every cycle.
- A reload value of one. This must pulse on every tick.
- Collisions between a software write and the terminal tick, and between a reload write and the terminal tick. A wrong priority shows up as a stray pulse or the wrong loaded value.

// File: rtl/tdec_pkg.sv
package tdec_pkg;

    typedef enum logic [1:0] {
        ST_STOPPED  = 2'd0,
        ST_COUNTING = 2'd1,
        ST_FINAL    = 2'd2
    } tdec_state_e;

    typedef enum logic [2:0] {
        OP_HOLD    = 3'd0,
        OP_SW_LOAD = 3'd1,
        OP_DEC     = 3'd2,
        OP_RELOAD  = 3'd3,
        OP_CLEAR   = 3'd4
    } tdec_op_e;

endpackage

// File: rtl/tdec_reload_reg.sv
module tdec_reload_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] value,
    output logic         nonzero,
    output logic         is_one
);
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     value <= '0;
        else if (wr_en) value <= wr_data;
    end

    assign nonzero = |value;
    assign is_one  = (value == ONE);

    // R9: a write is visible exactly one edge later
    assert_reload_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> value == $past(wr_data));
endmodule

// File: rtl/tdec_counter.sv
module tdec_counter
    import tdec_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  tdec_op_e     op,
    input  logic [W-1:0] sw_data,
    input  logic [W-1:0] rld_data,
    output logic [W-1:0] count,
    output logic         is_two
);
    localparam logic [W-1:0] ONE = W'(1);
    localparam logic [W-1:0] TWO = W'(2);

    logic [W-1:0] count_nxt;

    always_comb begin
        count_nxt = count;
        unique case (op)
            OP_HOLD:    count_nxt = count;
            OP_SW_LOAD: count_nxt = sw_data;
            OP_DEC:     count_nxt = count - ONE;
            OP_RELOAD:  count_nxt = rld_data;
            OP_CLEAR:   count_nxt = '0;
            default:    count_nxt = count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count <= '0;
        else        count <= count_nxt;
    end

    assign is_two = (count == TWO);

    // R3: a decrement step lowers the count by one
    assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DEC) |=> count == $past(count) - ONE);

    // R4: the controller never requests a decrement that would pass zero
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DEC) |-> count > ONE);
endmodule

// File: rtl/tdec_ctrl.sv
module tdec_ctrl
    import tdec_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sw_wr,
    input  logic        sw_zero,
    input  logic        sw_one,
    input  logic        tick,
    input  logic        rld_en,
    input  logic        rld_nonzero,
    input  logic        rld_one,
    input  logic        cnt_is_two,
    output tdec_op_e    op,
    output tdec_state_e state,
    output logic        evt
);
    tdec_state_e state_nxt;
    logic        fire;

    // next-state and datapath-operation selection
    always_comb begin
        state_nxt = state;
        op        = OP_HOLD;
        fire      = 1'b0;
        if (sw_wr) begin
            op = OP_SW_LOAD;
            if (sw_zero)     state_nxt = ST_STOPPED;
            else if (sw_one) state_nxt = ST_FINAL;
            else             state_nxt = ST_COUNTING;
        end else begin
            unique case (state)
                ST_STOPPED: begin
                    op = OP_HOLD;
                end
                ST_COUNTING: begin
                    if (tick) begin
                        op = OP_DEC;
                        if (cnt_is_two) state_nxt = ST_FINAL;
                    end
                end
                ST_FINAL: begin
                    if (tick) begin
                        fire = 1'b1;
                        if (rld_en && rld_nonzero) begin
                            op        = OP_RELOAD;
                            state_nxt = rld_one ? ST_FINAL : ST_COUNTING;
                        end else begin
                            op        = OP_CLEAR;
                            state_nxt = ST_STOPPED;
                        end
                    end
                end
                default: state_nxt = ST_STOPPED;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_STOPPED;
        else        state <= state_nxt;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt <= 1'b0;
        else        evt <= fire;
    end

    // R4: an event only follows a tick taken in FINAL
    assert_evt_from_final_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> ($past(state) == ST_FINAL && $past(tick) && !$past(sw_wr)));
endmodule

// File: rtl/tdec_top.sv
module tdec_top
    import tdec_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         cnt_wr_en,
    input  logic [W-1:0] cnt_wr_data,
    input  logic         rld_wr_en,
    input  logic [W-1:0] rld_wr_data,
    input  logic         rld_enable,
    output logic [W-1:0] count_val,
    output logic         zero_evt
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] rld_q;
    logic         rld_nz;
    logic         rld_is_one;
    logic         cnt_two;
    tdec_op_e     op;
    tdec_state_e  state;

    tdec_reload_reg #(.W(W)) u_rld (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rld_wr_en),
        .wr_data (rld_wr_data),
        .value   (rld_q),
        .nonzero (rld_nz),
        .is_one  (rld_is_one)
    );

    tdec_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_wr       (cnt_wr_en),
        .sw_zero     (cnt_wr_data == '0),
        .sw_one      (cnt_wr_data == ONE),
        .tick        (tick_en),
        .rld_en      (rld_enable),
        .rld_nonzero (rld_nz),
        .rld_one     (rld_is_one),
        .cnt_is_two  (cnt_two),
        .op          (op),
        .state       (state),
        .evt         (zero_evt)
    );

    tdec_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .sw_data  (cnt_wr_data),
        .rld_data (rld_q),
        .count    (count_val),
        .is_two   (cnt_two)
    );

    // R8: a software write always lands, whatever else happens that cycle
    assert_sw_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_en |=> (count_val == $past(cnt_wr_data) && !zero_evt));

    // R5: a parked counter stays at zero without a write
    assert_parked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (count_val == '0 && !cnt_wr_en) |=> (count_val == '0 && !zero_evt));

    // R6: a reload with a non-zero value takes that value
    assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_evt && $past(rld_enable) && $past(rld_q) != '0) |-> count_val == $past(rld_q));

    // R7: a zero reload value never reloads
    assert_zero_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_evt && $past(rld_enable) && $past(rld_q) == '0) |-> count_val == '0);

    // R5: the STOPPED state and a zero count go together
    assert_state_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOPPED) == (count_val == '0));
endmodule

// File: tb/tdec_top_test.sv
module tdec_top_test;

    typedef struct packed {
        logic        wr;
        logic [31:0] wdata;
        logic        rw;
        logic [31:0] rdata;
        logic        ren;
        logic        tick;
        logic [31:0] ecnt;
        logic        eevt;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'd3, 1'b0, 32'd0, 1'b0, 1'b0, 32'd3, 1'b0, 4'd2},  // R2 load
        '{1'b0, 32'd0, 1'b0, 32'd0, 1'b0, 1'b1, 32'd2, 1'b0, 4'd3},  // R3 step
        '{1'b0, 32'd0, 1'b0, 32'd0, 1'b0, 1'b0, 32'd2, 1'b0, 4'd3},  // R3 hold
        '{1'b0, 32'd0, 1'b0, 32'd0, 1'b0, 1'b1, 32'd1, 1'b0, 4'd3},
        '{1'b0, 32'd0, 1'b0, 32'd0, 1'b0, 1'b1, 32'd0, 1'b1, 4'd4},  // R4 event
        '{1'b0, 32'd0, 1'b0, 32'd0, 1'b0, 1'b1, 32'd0, 1'b0, 4'd5},  // R5 parked
        '{1'b0, 32'd0, 1'b0, 32'd0, 1'b0, 1'b1, 32'd0, 1'b0, 4'd5},
        '{1'b0, 32'd0, 1'b1, 32'd4, 1'b1, 1'b0, 32'd0, 1'b0, 4'd9},  // R9 reload write
        '{1'b1, 32'd2, 1'b0, 32'd0, 1'b1, 1'b0, 32'd2, 1'b0, 4'd2},
        '{1'b0, 32'd0, 1'b0, 32'd0, 1'b1, 1'b1, 32'd1, 1'b0, 4'd3},
        '{1'b0, 32'd0, 1'b0, 32'd0, 1'b1, 1'b1, 32'd4, 1'b1, 4'd6},  // R6 reload
        '{1'b0, 32'd0, 1'b0, 32'd0, 1'b1, 1'b1, 32'd3, 1'b0, 4'd6},
        '{1'b1, 32'd9, 1'b0, 32'd0, 1'b1, 1'b1, 32'd9, 1'b0, 4'd8},  // R8 write beats tick
        '{1'b1, 32'd1, 1'b0, 32'd0, 1'b1, 1'b0, 32'd1, 1'b0, 4'd2},
        '{1'b0, 32'd0, 1'b1, 32'd1, 1'b1, 1'b1, 32'd4, 1'b1, 4'd9},  // R9 old value used
        '{1'b1, 32'd1, 1'b0, 32'd0, 1'b1, 1'b0, 32'd1, 1'b0, 4'd2},
        '{1'b0, 32'd0, 1'b0, 32'd0, 1'b1, 1'b1, 32'd1, 1'b1, 4'd10}, // R10
        '{1'b0, 32'd0, 1'b0, 32'd0, 1'b1, 1'b1, 32'd1, 1'b1, 4'd10},
        '{1'b1, 32'd0, 1'b0, 32'd0, 1'b1, 1'b1, 32'd0, 1'b0, 4'd8},  // R8 zero write on terminal tick
        '{1'b0, 32'd0, 1'b1, 32'd0, 1'b1, 1'b0, 32'd0, 1'b0, 4'd9},
        '{1'b1, 32'd1, 1'b0, 32'd0, 1'b1, 1'b0, 32'd1, 1'b0, 4'd2},
        '{1'b0, 32'd0, 1'b0, 32'd0, 1'b1, 1'b1, 32'd0, 1'b1, 4'd7},  // R7 zero reload
        '{1'b0, 32'd0, 1'b0, 32'd0, 1'b1, 1'b1, 32'd0, 1'b0, 4'd7}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        cnt_wr_en = 1'b0;
    logic [31:0] cnt_wr_data = '0;
    logic        rld_wr_en = 1'b0;
    logic [31:0] rld_wr_data = '0;
    logic        rld_enable = 1'b0;
    logic [31:0] count_val;
    logic        zero_evt;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    tdec_top uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .cnt_wr_en   (cnt_wr_en),
        .cnt_wr_data (cnt_wr_data),
        .rld_wr_en   (rld_wr_en),
        .rld_wr_data (rld_wr_data),
        .rld_enable  (rld_enable),
        .count_val   (count_val),
        .zero_evt    (zero_evt)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic [31:0] wd, input logic rw,
                         input logic [31:0] rd, input logic ren, input logic tk);
        cnt_wr_en = wr; cnt_wr_data = wd;
        rld_wr_en = rw; rld_wr_data = rd;
        rld_enable = ren; tick_en = tk;
        @(posedge clk);
        #2;
        cnt_wr_en = 1'b0; rld_wr_en = 1'b0; tick_en = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        chk("R1 count in reset", count_val, 32'd0);
        chk("R1 event in reset", {31'd0, zero_evt}, 32'd0);
        rst_n = 1'b1;
        @(posedge clk); #2;
        chk("R1 count after release", count_val, 32'd0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].wr, VECS[i].wdata, VECS[i].rw, VECS[i].rdata, VECS[i].ren, VECS[i].tick);
            chk($sformatf("R%0d count vec %0d", VECS[i].req, i), count_val, VECS[i].ecnt);
            chk($sformatf("R%0d event vec %0d", VECS[i].req, i), {31'd0, zero_evt}, {31'd0, VECS[i].eevt});
        end

        // R3: large value steps down by one
        drive(1'b1, 32'hFFFF_FFFF, 1'b0, 32'd0, 1'b0, 1'b0);
        drive(1'b0, 32'd0, 1'b0, 32'd0, 1'b0, 1'b1);
        chk("R3 large step", count_val, 32'hFFFF_FFFE);

        // R2: writing zero gives no event, then ticks keep it parked
        drive(1'b1, 32'd0, 1'b0, 32'd0, 1'b0, 1'b0);
        chk("R2 zero write event", {31'd0, zero_evt}, 32'd0);
        drive(1'b0, 32'd0, 1'b0, 32'd0, 1'b0, 1'b1);
        chk("R5 parked after zero write", count_val, 32'd0);

        // R1: reset mid-run clears counter and reload register
        drive(1'b1, 32'd5, 1'b1, 32'd7, 1'b1, 1'b0);
        rst_n = 1'b0;
        #1;
        chk("R1 async clear", count_val, 32'd0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        drive(1'b1, 32'd1, 1'b0, 32'd0, 1'b1, 1'b0);
        drive(1'b0, 32'd0, 1'b0, 32'd0, 1'b1, 1'b1);
        chk("R1 reload cleared by reset (count)", count_val, 32'd0);
        chk("R1 reload cleared by reset (event)", {31'd0, zero_evt}, 32'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule